// File: doc/BRIEF.md
# Bus Error Capture Logger

This block sits beside an on-chip interconnect and records failed transactions. A separate detector reports each failed transaction on a one-cycle input strobe. The report carries an error class, an opcode, a burst length, the faulting address and a description of the initiator. The logger keeps the first report it sees in a small set of read-only log words. It then ignores every later report until software writes the clear register, so the record of the original failure is never overwritten by the errors that follow it.

A fault output, used as an interrupt or bus-abort request, is high while a record is held and the fault-enable bit is set. Software reads the log words over a simple register bus, decodes the fixed fields and writes the clear register. The logger is then ready to capture again.

Top module: `buserr_logger`

## Requirements
- R1: After reset the error-valid flag, the fault-enable bit and `fault_o` are 0. Address 0x00 reads the `CORE_ID` parameter and address 0x04 reads the `REV_ID` parameter.
- R2: Register reads complete one cycle after the read strobe. Offset 0x18 (log word 1) and any offset not listed in these requirements read 0.
- R3: One cycle after an accepted report, bit 0 of the error-valid register (0x0C) reads 1.
- R4: A report that arrives while the valid flag is set, and without a clear write in the same cycle, is dropped. The held record stays unchanged.
- R5: Writing a value with bit 0 = 1 to the clear register (0x10) drops the valid flag on that clock edge. Writing a value with bit 0 = 0 has no effect.
- R6: When a clear write and a new report arrive in the same cycle, the clear takes effect first and the new report is captured.
- R7: Log word 0 (0x14) holds the opcode in bits [4:1], the error class in bits [10:8] and the burst length in bits [21:16]. All its other bits are 0. The error class is 3 bits (0 slave error, 1 decode error, 2 unsupported, 3 power down, 4 security, 5 hidden security, 6 timeout, 7 reserved). The opcode is 4 bits (0 read, 1 wrap read, 2 linked read, 3 exclusive read, 4 write, 5 wrap write, 6 conditional write, 8 preamble, 9 urgency, all other values reserved).
- R8: Log word 3 (0x20) holds the faulting address. In log word 5 (0x28), bit 0 is 0 for a CPU initiator and 1 for a non-CPU initiator. For a CPU initiator, bits [3:2] hold the CPU index `err_init_id[1:0]`. For a non-CPU initiator, bits [3:2] hold `err_init_id[6:5]` and bits [11:7] hold `err_init_id[4:0]`. All other bits of log word 5 are 0.
- R9: Bit 0 of the fault-enable register (0x08) is readable and writable. `fault_o` equals valid AND enable, and it updates on the same edge as either of them.
- R10: Writes to the identification, error-valid and log registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |
| err_valid | input | 1 | Failed-transaction report strobe |
| err_class | input | 3 | Error class code |
| err_opc | input | 4 | Opcode of the failed transaction |
| err_len | input | 6 | Burst length |
| err_addr | input | 32 | Faulting address |
| err_noncpu | input | 1 | 1 for a non-CPU initiator |
| err_init_id | input | 7 | Initiator ID (CPU index in bits [1:0]) |
| fault_o | output | 1 | Fault request level |

## Verification
The hardest case to reach from the ports is a clear write and a new report landing on the same clock edge. At that edge the priority between dropping a report and accepting one decides which record survives. The bench first captures one record and then, in a single cycle, drives the register write to the clear offset together with a report carrying different field values. Afterwards it reads the valid flag and every log word to confirm that the second report was captured. A report sent while the record is held is also checked field by field, to show that the first record stays intact.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CORE_ID = 8'h00;
  localparam logic [7:0] OFS_REV_ID  = 8'h04;
  localparam logic [7:0] OFS_FLT_EN  = 8'h08;
  localparam logic [7:0] OFS_VALID   = 8'h0C;
  localparam logic [7:0] OFS_CLEAR   = 8'h10;
  localparam logic [7:0] OFS_LOG0    = 8'h14;
  localparam logic [7:0] OFS_LOG1    = 8'h18;
  localparam logic [7:0] OFS_LOG3    = 8'h20;
  localparam logic [7:0] OFS_LOG5    = 8'h28;

  typedef struct packed {
    logic [2:0] eclass;
    logic [3:0] opc;
    logic [5:0] len;
    logic       noncpu;
    logic [6:0] init_id;
  } err_rec_t;
endpackage

// File: rtl/buserr_capture.sv
module buserr_capture
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              rpt_vld_i,
  input  err_rec_t          rpt_i,
  input  logic [ADDR_W-1:0] rpt_addr_i,
  output logic              vld_o,
  output logic              vld_nxt_o,
  output err_rec_t          rec_o,
  output logic [ADDR_W-1:0] rec_addr_o
);
  logic take;
  // clear has priority, then an arriving report is accepted
  assign take      = rpt_vld_i && (!vld_o || clr_i);
  assign vld_nxt_o = take || (vld_o && !clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o      <= 1'b0;
      rec_o      <= '0;
      rec_addr_o <= '0;
    end else begin
      vld_o <= vld_nxt_o;
      if (take) begin
        rec_o      <= rpt_i;
        rec_addr_o <= rpt_addr_i;
      end
    end
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    rpt_vld_i |=> vld_o);
  a_r4_hold_first: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !clr_i) |=> ($stable(rec_o) && $stable(rec_addr_o) && vld_o));
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !rpt_vld_i) |=> !vld_o);
  a_r6_clear_and_new: assert property (@(posedge clk) disable iff (rst)
    (clr_i && rpt_vld_i) |=> (vld_o && rec_o == $past(rpt_i)));
endmodule

// File: rtl/buserr_regs.sv
module buserr_regs
  import buserr_pkg::*;
#(
  parameter int          REG_AW  = 8,
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] CORE_ID = 32'h0000_E10C,
  parameter logic [31:0] REV_ID  = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              vld_i,
  input  err_rec_t          rec_i,
  input  logic [ADDR_W-1:0] rec_addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clr_o,
  output logic              en_o,
  output logic              en_nxt_o
);
  localparam int PAD = (REG_AW > 8) ? REG_AW - 8 : 0;

  logic [7:0]        ofs;
  logic              hi_zero;
  logic [DATA_W-1:0] word0, word5, word3, rd_mux;

  assign ofs = addr_i[7:0];
  generate
    if (PAD > 0) begin : g_hi
      assign hi_zero = (addr_i[REG_AW-1:8] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign clr_o    = wr_en_i && hi_zero && ofs == OFS_CLEAR && wdata_i[0];
  assign en_nxt_o = (wr_en_i && hi_zero && ofs == OFS_FLT_EN) ? wdata_i[0] : en_o;

  always_comb begin
    word0        = '0;
    word0[4:1]   = rec_i.opc;
    word0[10:8]  = rec_i.eclass;
    word0[21:16] = rec_i.len;
    word5        = '0;
    word5[0]     = rec_i.noncpu;
    if (rec_i.noncpu) begin
      word5[3:2]  = rec_i.init_id[6:5];
      word5[11:7] = rec_i.init_id[4:0];
    end else begin
      word5[3:2]  = rec_i.init_id[1:0];
    end
    word3 = DATA_W'(rec_addr_i);
  end

  always_comb begin
    rd_mux = '0;
    if (hi_zero) begin
      case (ofs)
        OFS_CORE_ID: rd_mux = CORE_ID;
        OFS_REV_ID:  rd_mux = REV_ID;
        OFS_FLT_EN:  rd_mux = {{(DATA_W-1){1'b0}}, en_o};
        OFS_VALID:   rd_mux = {{(DATA_W-1){1'b0}}, vld_i};
        OFS_LOG0:    rd_mux = word0;
        OFS_LOG1:    rd_mux = '0;
        OFS_LOG3:    rd_mux = word3;
        OFS_LOG5:    rd_mux = word5;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      en_o <= en_nxt_o;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  a_r9_enable_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && hi_zero && ofs == OFS_FLT_EN) |=> (en_o == $past(wdata_i[0])));
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/buserr_fault.sv
module buserr_fault (
  input  logic clk,
  input  logic rst,
  input  logic vld_nxt_i,
  input  logic en_nxt_i,
  output logic fault_o
);
  always_ff @(posedge clk) begin
    if (rst) fault_o <= 1'b0;
    else     fault_o <= vld_nxt_i && en_nxt_i;
  end
endmodule

// File: rtl/buserr_logger.sv
module buserr_logger
  import buserr_pkg::*;
#(
  parameter int          REG_AW  = 8,
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] CORE_ID = 32'h0000_E10C,
  parameter logic [31:0] REV_ID  = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              err_valid,
  input  logic [2:0]        err_class,
  input  logic [3:0]        err_opc,
  input  logic [5:0]        err_len,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_noncpu,
  input  logic [6:0]        err_init_id,
  output logic              fault_o
);
  err_rec_t          rpt, rec;
  logic [ADDR_W-1:0] rec_addr;
  logic              vld, vld_nxt, clr, en, en_nxt;

  assign rpt = '{eclass: err_class, opc: err_opc, len: err_len,
                 noncpu: err_noncpu, init_id: err_init_id};

  buserr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .clr_i(clr), .rpt_vld_i(err_valid),
    .rpt_i(rpt), .rpt_addr_i(err_addr), .vld_o(vld),
    .vld_nxt_o(vld_nxt), .rec_o(rec), .rec_addr_o(rec_addr));

  buserr_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W),
                .CORE_ID(CORE_ID), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(reg_wr_en), .rd_en_i(reg_rd_en),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .vld_i(vld), .rec_i(rec),
    .rec_addr_i(rec_addr), .rdata_o(reg_rdata), .clr_o(clr),
    .en_o(en), .en_nxt_o(en_nxt));

  buserr_fault u_flt (
    .clk(clk), .rst(rst), .vld_nxt_i(vld_nxt), .en_nxt_i(en_nxt),
    .fault_o(fault_o));

  a_r9_fault_level: assert property (@(posedge clk) disable iff (rst)
    fault_o == (vld && en));
  a_r1_fault_needs_record: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> vld);
endmodule

// File: tb/buserr_logger_test.sv
module buserr_logger_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en, reg_rd_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        err_valid, err_noncpu;
  logic [2:0]  err_class;
  logic [3:0]  err_opc;
  logic [5:0]  err_len;
  logic [31:0] err_addr;
  logic [6:0]  err_init_id;
  logic        fault_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  buserr_logger uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_valid(err_valid), .err_class(err_class), .err_opc(err_opc),
    .err_len(err_len), .err_addr(err_addr), .err_noncpu(err_noncpu),
    .err_init_id(err_init_id), .fault_o(fault_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w0(logic [2:0] c, logic [3:0] o, logic [5:0] l);
    return (32'(o) << 1) | (32'(c) << 8) | (32'(l) << 16);
  endfunction

  function automatic logic [31:0] w5(logic nc, logic [6:0] id);
    if (nc) return 32'd1 | (32'(id[6:5]) << 2) | (32'(id[4:0]) << 7);
    return 32'(id[1:0]) << 2;
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic set_rpt(logic [2:0] c, logic [3:0] o, logic [5:0] l,
                         logic [31:0] a, logic nc, logic [6:0] id);
    err_valid = 1'b1; err_class = c; err_opc = o; err_len = l;
    err_addr = a; err_noncpu = nc; err_init_id = id;
  endtask

  task automatic report(logic [2:0] c, logic [3:0] o, logic [5:0] l,
                        logic [31:0] a, logic nc, logic [6:0] id);
    @(negedge clk); set_rpt(c, o, l, a, nc, id);
    @(negedge clk); err_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 fault after reset", 32'(fault_o), 0);
    rd(8'h00, d); chk("R1 core id", d, 32'h0000_E10C);
    rd(8'h04, d); chk("R1 revision", d, 32'h0000_0001);
    rd(8'h0C, d); chk("R1 valid after reset", d, 0);
    rd(8'h08, d); chk("R1 enable after reset", d, 0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    report(3'd4, 4'd3, 6'd17, 32'hDEAD_BEEF, 1'b0, 7'h02);
    rd(8'h0C, d); chk("R3 valid set", d, 1);
    rd(8'h14, d); chk("R7 word0", d, w0(3'd4, 4'd3, 6'd17));
    rd(8'h20, d); chk("R8 address", d, 32'hDEAD_BEEF);
    rd(8'h28, d); chk("R8 cpu word5", d, 32'h8);
    chk("R9 fault held low when disabled", 32'(fault_o), 0);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    report(3'd6, 4'd9, 6'd2, 32'h1234_5678, 1'b1, 7'h7F);
    rd(8'h14, d); chk("R4 word0 kept", d, w0(3'd4, 4'd3, 6'd17));
    rd(8'h20, d); chk("R4 address kept", d, 32'hDEAD_BEEF);
    rd(8'h28, d); chk("R4 word5 kept", d, 32'h8);
  endtask

  task automatic t_fault_enable;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R9 fault after enable", 32'(fault_o), 1);
    rd(8'h08, d); chk("R9 enable readback", d, 1);
    wr(8'h10, 32'h2);
    rd(8'h0C, d); chk("R5 clear with bit0=0 ignored", d, 1);
    chk("R5 fault kept", 32'(fault_o), 1);
    wr(8'h10, 32'h1);
    chk("R5 fault drops after clear", 32'(fault_o), 0);
    rd(8'h0C, d); chk("R5 valid cleared", d, 0);
  endtask

  task automatic t_noncpu_fields;
    logic [31:0] d;
    report(3'd7, 4'hF, 6'h3F, 32'h0000_0040, 1'b1, 7'h5B);
    chk("R9 fault on capture while enabled", 32'(fault_o), 1);
    rd(8'h14, d); chk("R7 all-ones fields", d, 32'h003F_071E);
    rd(8'h28, d); chk("R8 noncpu word5", d, w5(1'b1, 7'h5B));
  endtask

  task automatic t_clear_and_report;
    logic [31:0] d;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h1;
    set_rpt(3'd1, 4'd5, 6'd8, 32'hCAFE_0004, 1'b0, 7'h03);
    @(negedge clk); reg_wr_en = 1'b0; err_valid = 1'b0;
    chk("R6 fault stays", 32'(fault_o), 1);
    rd(8'h0C, d); chk("R6 valid kept", d, 1);
    rd(8'h14, d); chk("R6 new word0", d, w0(3'd1, 4'd5, 6'd8));
    rd(8'h20, d); chk("R6 new address", d, 32'hCAFE_0004);
    rd(8'h28, d); chk("R6 new word5", d, w5(1'b0, 7'h03));
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(8'h00, 32'h5555_5555);
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h20, 32'h0);
    rd(8'h00, d); chk("R10 id unchanged", d, 32'h0000_E10C);
    rd(8'h0C, d); chk("R10 valid unchanged", d, 1);
    rd(8'h14, d); chk("R10 word0 unchanged", d, w0(3'd1, 4'd5, 6'd8));
    rd(8'h20, d); chk("R10 address unchanged", d, 32'hCAFE_0004);
    rd(8'h18, d); chk("R2 log word1 zero", d, 0);
    rd(8'h44, d); chk("R2 unmapped zero", d, 0);
    wr(8'h08, 32'h0);
    chk("R9 fault off after disable", 32'(fault_o), 0);
  endtask

  initial begin
    rst = 1'b1; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
    err_valid = 0; err_class = 0; err_opc = 0; err_len = 0; err_addr = 0;
    err_noncpu = 0; err_init_id = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_capture;
    t_hold;
    t_fault_enable;
    t_noncpu_fields;
    t_clear_and_report;
    t_readonly;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule